// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block sits between a MAC receive byte stream and a shared memory that holds a circular ring of receive descriptors. When a frame starts, it looks at the current descriptor. If the controller owns that descriptor, it fetches the buffer address and the buffer capacity. It then stores the frame bytes one at a time through a synchronous 16-bit memory port with byte enables. If a frame does not fit in one buffer, the engine chains to the next descriptor. Before it closes the full buffer, it confirms that it owns that next descriptor.

When a frame ends, the engine closes the buffer that holds the last byte. It first writes the message length, which includes the 4 CRC bytes. It then writes the flag byte with ownership returned to the host, and pulses `rx_done_o` in the same cycle. If the current descriptor is host-owned when a frame starts, the frame is dropped and `rx_missed_o` pulses. If a frame outgrows its buffer while the next descriptor is host-owned, the buffer is closed with buffer and overflow errors, and the rest of the frame is discarded.

Descriptor k starts at word address `ring_base_i + 4*k`. Its four 16-bit words are:
- word 0: low 16 bits of the buffer address.
- word 1: flag byte in bits 15:8 and the high address byte in bits 7:0.
- word 2: negated buffer capacity.
- word 3: message length.

Top module: `rxr_rx_ring`

## Requirements
- R1: After reset `mem_req_o`, `rx_done_o` and `rx_missed_o` are low until a start-of-frame byte arrives.
- R2: On a start-of-frame byte, word 1 of the current descriptor is read. If bit 15 (OWN) is 0, `rx_missed_o` pulses for one cycle, nothing is written to memory, and bytes up to end-of-frame are discarded.
- R3: Frame bytes are stored in order from byte address {word1[7:0], word0}. An even byte address uses lane bits 7:0 (`mem_be_o`=01) and an odd byte address uses bits 15:8 (`mem_be_o`=10). `mem_addr_o` is the byte address shifted right by one.
- R4: Buffer capacity is the low 12 bits of the two's-complement negation of word 2. A result of 0 means 4096 bytes.
- R5: Word 3 is written only for the buffer that holds the frame's last byte. Its value is the total number of frame bytes, including the 4 CRC bytes, in bits 11:0, with bits 15:12 zero.
- R6: The flag byte sits in word-1 bits 15:8 with ENP=bit0, STP=bit1, BUFF=bit2, CRC=bit3, OFLO=bit4, FRAM=bit5, ERR=bit6 and OWN=bit7. Bits 7:0 keep the high address byte. A clean frame held in one buffer leaves flags 0x03.
- R7: When a byte arrives for a full buffer and the next descriptor is controller-owned, the full buffer is closed with STP only (first buffer) or no flags (middle buffer), and the byte continues in the next buffer.
- R8: A CRC or framing error flagged with the end-of-frame byte sets CRC (0x08) or FRAM (0x20), together with ERR, only on the buffer holding the end of the packet. ERR is the OR of BUFF, CRC, OFLO and FRAM.
- R9: When a byte arrives for a full buffer and the next descriptor is host-owned, the current buffer is closed as the last buffer with ENP|BUFF|OFLO|ERR (plus STP if it is the first buffer). Its length is the number of bytes stored, the rest of the frame is dropped, and the next descriptor is not written.
- R10: The flag write that returns ownership comes in the cycle right after the length write. `rx_done_o` pulses for exactly that cycle.
- R11: The ring index advances by one for each closed buffer and wraps modulo 2^`ring_len_i`. `ring_len_i` carries bits 15:13 of the ring configuration word.
- R12: Bytes that arrive outside a frame have no effect. Valid bytes arrive at least 10 clock cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ring_base_i | input | 23 | Word address of descriptor 0, 4-word aligned |
| ring_len_i | input | 3 | log2 of the number of ring entries |
| rx_data_i | input | 8 | Received byte |
| rx_valid_i | input | 1 | Byte strobe |
| rx_sof_i | input | 1 | Byte is the first of a frame |
| rx_eof_i | input | 1 | Byte is the last of a frame |
| rx_crc_err_i | input | 1 | CRC error, valid with end-of-frame |
| rx_fram_err_i | input | 1 | Framing error, valid with end-of-frame |
| mem_req_o | output | 1 | Memory access this cycle |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 23 | Word address |
| mem_be_o | output | 2 | Byte lane enables for writes |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, one cycle after the read request |
| rx_done_o | output | 1 | Pulse when a frame's last buffer is handed to the host |
| rx_missed_o | output | 1 | Pulse when a frame is dropped for lack of a descriptor |

## Verification
The assertions assume the following about the inputs:
- A byte strobe arrives only while the engine is idle. The longest per-byte path is nine cycles, so the stimulus spaces bytes twelve cycles apart.
- `ring_len_i` stays constant while frames are in flight.
- The descriptor base is 4-word aligned, so the low two bits of a descriptor access give the word offset.
- Frames are well formed, with no start-of-frame byte inside an open frame.

The bench sweeps frame lengths across one, two and three buffers of a small ring. It rewrites all descriptors between frames, so every check refers to a known memory image.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int BYTE_AW = 24;          // {high byte, low word}
  localparam int WORD_AW = BYTE_AW - 1;
  localparam int LEN_W   = 12;

  localparam int F_ENP  = 0;
  localparam int F_STP  = 1;
  localparam int F_BUFF = 2;
  localparam int F_CRC  = 3;
  localparam int F_OFLO = 4;
  localparam int F_FRAM = 5;
  localparam int F_ERR  = 6;
  localparam int F_OWN  = 7;

  localparam logic [1:0] W_ADDR = 2'd0;
  localparam logic [1:0] W_FLAG = 2'd1;
  localparam logic [1:0] W_SIZE = 2'd2;
  localparam logic [1:0] W_MLEN = 2'd3;

  typedef enum logic [3:0] {
    S_IDLE, S_CHK, S_OWN, S_CLMID, S_RDLO, S_RDSZ, S_GOTSZ, S_WRB, S_WLEN, S_WFLG
  } rxr_state_e;
endpackage

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr #(
  parameter int MAX_LOG = 7,
  localparam int IW = MAX_LOG
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    log2_i,
  input  logic          adv_i,
  output logic [IW-1:0] idx_o,
  output logic [IW-1:0] nxt_o
);
  logic [IW-1:0] mask;

  assign mask  = ~({IW{1'b1}} << log2_i);
  assign nxt_o = (idx_o + 1'b1) & mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    idx_o <= '0;
    else if (adv_i) idx_o <= nxt_o;
  end

  p_idx_in_ring_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_o & ~mask) == '0);
endmodule

// File: rtl/rxr_buf_cursor.sv
module rxr_buf_cursor #(
  parameter int AW = 24,
  parameter int SW = 12,
  localparam int CW = SW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] base_i,
  input  logic [SW-1:0] size_neg_i,
  input  logic          step_i,
  output logic [AW-1:0] addr_o,
  output logic          full_o
);
  logic [AW-1:0] base_q;
  logic [CW-1:0] cap_q, cnt_q;
  logic [SW-1:0] mag;

  assign mag    = ~size_neg_i + 1'b1;
  assign addr_o = base_q + AW'(cnt_q);
  assign full_o = (cnt_q == cap_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cap_q  <= '0;
      cnt_q  <= '0;
    end else if (load_i) begin
      base_q <= base_i;
      cap_q  <= (mag == '0) ? CW'(1 << SW) : {1'b0, mag};
      cnt_q  <= '0;
    end else if (step_i) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  p_fill_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= cap_q);
endmodule

// File: rtl/rxr_rx_ring.sv
module rxr_rx_ring
  import rxr_pkg::*;
#(
  parameter int MAX_LOG = 7,
  localparam int IW = MAX_LOG
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [WORD_AW-1:0] ring_base_i,
  input  logic [2:0]         ring_len_i,
  input  logic [7:0]         rx_data_i,
  input  logic               rx_valid_i,
  input  logic               rx_sof_i,
  input  logic               rx_eof_i,
  input  logic               rx_crc_err_i,
  input  logic               rx_fram_err_i,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [WORD_AW-1:0] mem_addr_o,
  output logic [1:0]         mem_be_o,
  output logic [15:0]        mem_wdata_o,
  input  logic [15:0]        mem_rdata_i,
  output logic               rx_done_o,
  output logic               rx_missed_o
);
  rxr_state_e state;
  logic chain, first, drop, in_frame, ovf;
  logic [7:0] hold_d, nhi, hi_cur;
  logic hold_eof, hold_crc, hold_fram;
  logic [LEN_W-1:0] total;
  logic [15:0] lo_q;
  logic [IW-1:0] idx, nxt;
  logic [BYTE_AW-1:0] byte_addr;
  logic buf_full;
  logic [7:0] fl_end, fl_mid;

  rxr_ring_ptr #(.MAX_LOG(MAX_LOG)) u_ptr (
    .clk_i, .rst_ni, .log2_i(ring_len_i),
    .adv_i(state == S_CLMID || state == S_WFLG),
    .idx_o(idx), .nxt_o(nxt)
  );

  rxr_buf_cursor #(.AW(BYTE_AW), .SW(LEN_W)) u_cur (
    .clk_i, .rst_ni, .load_i(state == S_GOTSZ),
    .base_i({nhi, lo_q}), .size_neg_i(mem_rdata_i[LEN_W-1:0]),
    .step_i(state == S_WRB), .addr_o(byte_addr), .full_o(buf_full)
  );

  function automatic logic [WORD_AW-1:0] desc_at(input logic [IW-1:0] i, input logic [1:0] off);
    return ring_base_i + WORD_AW'({i, off});
  endfunction

  always_comb begin
    fl_mid         = '0;
    fl_mid[F_STP]  = first;
    fl_end         = '0;
    fl_end[F_ENP]  = 1'b1;
    fl_end[F_STP]  = first;
    fl_end[F_BUFF] = ovf;
    fl_end[F_OFLO] = ovf;
    fl_end[F_CRC]  = hold_eof & hold_crc;
    fl_end[F_FRAM] = hold_eof & hold_fram;
    fl_end[F_ERR]  = ovf | (hold_eof & (hold_crc | hold_fram));
  end

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_be_o    = 2'b11;
    mem_wdata_o = '0;
    rx_done_o   = 1'b0;
    rx_missed_o = 1'b0;
    unique case (state)
      S_CHK:   begin mem_req_o = 1'b1; mem_addr_o = desc_at(chain ? nxt : idx, W_FLAG); end
      S_OWN:   rx_missed_o = !mem_rdata_i[15] && !chain;
      S_CLMID: begin
        mem_req_o = 1'b1; mem_we_o = 1'b1;
        mem_addr_o = desc_at(idx, W_FLAG); mem_wdata_o = {fl_mid, hi_cur};
      end
      S_RDLO:  begin mem_req_o = 1'b1; mem_addr_o = desc_at(idx, W_ADDR); end
      S_RDSZ:  begin mem_req_o = 1'b1; mem_addr_o = desc_at(idx, W_SIZE); end
      S_WRB:   begin
        mem_req_o = 1'b1; mem_we_o = 1'b1;
        mem_addr_o = byte_addr[BYTE_AW-1:1];
        mem_be_o = byte_addr[0] ? 2'b10 : 2'b01;
        mem_wdata_o = {hold_d, hold_d};
      end
      S_WLEN:  begin
        mem_req_o = 1'b1; mem_we_o = 1'b1;
        mem_addr_o = desc_at(idx, W_MLEN); mem_wdata_o = 16'(total);
      end
      S_WFLG:  begin
        mem_req_o = 1'b1; mem_we_o = 1'b1; rx_done_o = 1'b1;
        mem_addr_o = desc_at(idx, W_FLAG); mem_wdata_o = {fl_end, hi_cur};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state <= S_IDLE;
      {chain, first, drop, in_frame, ovf} <= '0;
      {hold_d, hold_eof, hold_crc, hold_fram} <= '0;
      nhi <= '0; hi_cur <= '0; lo_q <= '0; total <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (rx_valid_i) begin
          hold_d <= rx_data_i; hold_eof <= rx_eof_i;
          hold_crc <= rx_crc_err_i; hold_fram <= rx_fram_err_i;
          if (drop) begin
            if (rx_eof_i) drop <= 1'b0;
          end else if (rx_sof_i) begin
            first <= 1'b1; total <= '0; chain <= 1'b0; ovf <= 1'b0;
            in_frame <= 1'b1; state <= S_CHK;
          end else if (in_frame) begin
            chain <= buf_full;
            state <= buf_full ? S_CHK : S_WRB;
          end
        end
        S_CHK: state <= S_OWN;
        S_OWN: if (mem_rdata_i[15]) begin
          nhi   <= mem_rdata_i[7:0];
          state <= chain ? S_CLMID : S_RDLO;
        end else begin
          drop <= !hold_eof; in_frame <= 1'b0;
          ovf  <= chain;                       // no room to chain: close as overflow
          state <= chain ? S_WLEN : S_IDLE;
        end
        S_CLMID: begin first <= 1'b0; state <= S_RDLO; end
        S_RDLO:  state <= S_RDSZ;
        S_RDSZ:  begin lo_q <= mem_rdata_i; state <= S_GOTSZ; end
        S_GOTSZ: begin hi_cur <= nhi; state <= S_WRB; end
        S_WRB: begin
          total <= total + 1'b1;
          if (hold_eof) begin in_frame <= 1'b0; state <= S_WLEN; end
          else state <= S_IDLE;
        end
        S_WLEN: state <= S_WFLG;
        S_WFLG: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  p_byte_gap_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i |-> state == S_IDLE);
  p_own_last_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done_o |-> $past(mem_we_o && mem_addr_o[1:0] == W_MLEN) && mem_addr_o[1:0] == W_FLAG);
  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done_o |=> !rx_done_o);
  p_len_field_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done_o |-> $past(mem_wdata_o[15:12]) == 4'h0);
  p_err_summary_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done_o |-> mem_wdata_o[8+F_ERR] == |{mem_wdata_o[8+F_BUFF], mem_wdata_o[8+F_CRC],
                                            mem_wdata_o[8+F_OFLO], mem_wdata_o[8+F_FRAM]});
  p_missed_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_missed_o |-> !mem_we_o ##1 !mem_req_o);
endmodule

// File: tb/rxr_rx_ring_test.sv
`timescale 1ns/1ps
module rxr_rx_ring_test;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic [7:0] rx_data = '0;
  logic rx_valid = 0, rx_sof = 0, rx_eof = 0, rx_crc = 0, rx_fram = 0;
  logic mem_req, mem_we, done, missed;
  logic [22:0] mem_addr;
  logic [1:0] mem_be;
  logic [15:0] mem_wdata, mem_rdata;
  logic [15:0] mem [0:1023];
  int checks = 0, errors = 0, done_cnt = 0, missed_cnt = 0, idx_exp = 0;

  always #2 clk = ~clk;

  rxr_rx_ring uut (
    .clk_i(clk), .rst_ni, .ring_base_i(23'd0), .ring_len_i(3'd2),
    .rx_data_i(rx_data), .rx_valid_i(rx_valid), .rx_sof_i(rx_sof), .rx_eof_i(rx_eof),
    .rx_crc_err_i(rx_crc), .rx_fram_err_i(rx_fram),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_be_o(mem_be),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .rx_done_o(done), .rx_missed_o(missed)
  );

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        if (mem_be[0]) mem[mem_addr[9:0]][7:0]  <= mem_wdata[7:0];
        if (mem_be[1]) mem[mem_addr[9:0]][15:8] <= mem_wdata[15:8];
      end else mem_rdata <= mem[mem_addr[9:0]];
    end
    if (done) done_cnt <= done_cnt + 1;
    if (missed) missed_cnt <= missed_cnt + 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // descriptor k: buffer at byte 0x5A_0200 + 32k, capacity 8
  task automatic set_desc(input int k, input bit own);
    mem[4*k]   = 16'h0200 + 16'(32*k);
    mem[4*k+1] = {own ? 8'h80 : 8'h00, 8'h5A};
    mem[4*k+2] = 16'hFFF8;
    mem[4*k+3] = 16'hAAAA;
    for (int w = 0; w < 4; w++) mem[10'h100 + 16*k + w] = 16'hEEEE;
  endtask

  task automatic send_byte(input logic [7:0] d, input bit s, input bit e, input bit c, input bit f);
    @(negedge clk);
    rx_data = d; rx_sof = s; rx_eof = e; rx_crc = c; rx_fram = f; rx_valid = 1;
    @(negedge clk);
    rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_crc = 0; rx_fram = 0;
    repeat (11) @(negedge clk);
  endtask

  task automatic send_frame(input int len, input int seed, input bit c, input bit f);
    for (int j = 0; j < len; j++)
      send_byte(8'(seed + j), j == 0, j == len - 1, c && j == len - 1, f && j == len - 1);
    repeat (20) @(negedge clk);
  endtask

  function automatic logic [7:0] buf_byte(input int k, input int o);
    logic [15:0] w;
    w = mem[10'h100 + 16*k + o/2];
    return (o % 2) ? w[15:8] : w[7:0];
  endfunction

  initial begin
    #(4*150000);
    errors++;
    $display("FAIL watchdog actual hung expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int d0, m0, nb, k, bad;
    logic [7:0] fl;
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    for (int i = 0; i < 4; i++) set_desc(i, 1);
    repeat (3) @(negedge clk);
    chk("R1 req in reset", {29'd0, mem_req, done, missed}, 0);
    rst_ni = 1;
    repeat (3) @(negedge clk);
    chk("R1 idle after reset", {29'd0, mem_req, done, missed}, 0);

    // sweep lengths over one, two and three buffers
    for (int len = 1; len <= 24; len++) begin
      for (int i = 0; i < 4; i++) set_desc(i, 1);
      d0 = done_cnt; m0 = missed_cnt;
      send_frame(len, len * 7, len == 5, len == 11);
      nb = (len + 7) / 8;
      bad = 0;
      for (int j = 0; j < len; j++)
        if (buf_byte((idx_exp + j / 8) % 4, j % 8) !== 8'(len * 7 + j)) bad++;
      chk("R3 R4 data placement", bad, 0);
      for (int b = 0; b < nb; b++) begin
        k = (idx_exp + b) % 4;
        fl = (b == 0 ? 8'h02 : 8'h00) | (b == nb - 1 ? 8'h01 : 8'h00);
        if (b == nb - 1 && len == 5)  fl |= 8'h48;
        if (b == nb - 1 && len == 11) fl |= 8'h60;
        chk("R6 R7 R8 flag word", mem[4*k+1], {fl, 8'h5A});
        chk("R5 length word", mem[4*k+3], (b == nb - 1) ? len : 16'hAAAA);
      end
      if (nb < 4) chk("R11 next descriptor untouched", mem[4*((idx_exp + nb) % 4) + 1], 16'h805A);
      chk("R10 done pulses", done_cnt - d0, 1);
      chk("R2 no miss", missed_cnt - m0, 0);
      idx_exp = (idx_exp + nb) % 4;
    end

    // overflow: next descriptor host-owned
    for (int i = 0; i < 4; i++) set_desc(i, 1);
    set_desc((idx_exp + 1) % 4, 0);
    d0 = done_cnt; m0 = missed_cnt;
    send_frame(13, 3, 0, 0);
    chk("R9 overflow flags", mem[4*idx_exp+1], 16'h575A);
    chk("R9 overflow length", mem[4*idx_exp+3], 8);
    chk("R9 next flag untouched", mem[4*((idx_exp + 1) % 4) + 1], 16'h005A);
    chk("R9 next length untouched", mem[4*((idx_exp + 1) % 4) + 3], 16'hAAAA);
    chk("R9 one done", done_cnt - d0, 1);
    idx_exp = (idx_exp + 1) % 4;

    // missed frame: current descriptor host-owned
    d0 = done_cnt; m0 = missed_cnt;
    send_frame(3, 9, 0, 0);
    chk("R2 missed pulse", missed_cnt - m0, 1);
    chk("R2 no done", done_cnt - d0, 0);
    chk("R2 descriptor untouched", mem[4*idx_exp+1], 16'h005A);
    chk("R2 buffer untouched", mem[10'h100 + 16*idx_exp], 16'hEEEE);

    // stray bytes outside a frame
    set_desc(idx_exp, 1);
    d0 = done_cnt;
    send_byte(8'h11, 0, 0, 0, 0);
    send_byte(8'h22, 0, 1, 0, 0);
    repeat (20) @(negedge clk);
    chk("R12 stray no done", done_cnt - d0, 0);
    chk("R12 stray no write", mem[10'h100 + 16*idx_exp], 16'hEEEE);
    chk("R12 stray flags kept", mem[4*idx_exp+1], 16'h805A);

    // recovery frame on the same index
    send_frame(4, 40, 0, 0);
    chk("R6 clean after miss", mem[4*idx_exp+1], 16'h035A);
    chk("R5 clean length", mem[4*idx_exp+3], 4);
    chk("R3 lane high byte", mem[10'h100 + 16*idx_exp], 16'h2928);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule